// File: doc/BRIEF.md
# Prescaled Match and Capture Timer

This block is a general-purpose timer for a peripheral subsystem. A prescale counter divides the timer clock, and each time it wraps it advances a timer count. Four match channels watch the count and act on it: each can raise a flag, restart the count, halt it, and drive a dedicated output pin. Four capture channels record the count when their input pins change level. A pause input freezes counting, and a software clear holds both counters at zero.

A run/clear/pause state machine governs counting. Its states are ST_IDLE (stopped), ST_CLEAR (both counters held at zero), ST_PAUSE (held by the pause pin) and ST_COUNT (advancing). Any state moves to ST_CLEAR while the clear bit is set. Otherwise a state moves to ST_IDLE when the run bit is low. With run high it moves to ST_PAUSE while the pause pin is high, and to ST_COUNT when that pin is low. Counting is gated by the live run, clear and pause values, so a stop or a pause takes effect at the very next edge. Software configures the block through a single-cycle register port with word addresses. Reads are combinational.

Register word addresses: 0 control (bit 0 run, bit 1 clear), 1 interrupt flags, 2 interrupt enables, 3 timer count, 4 prescale limit, 5 prescale count, 6 match configuration, 7 capture configuration, 8 to 11 match values for channels 0 to 3, 12 to 15 captured values for channels 0 to 3, 16 match pin levels. Addresses 3, 5, 12 to 16 are read-only.

Top module: `tmr_match_capture`

## Requirements
- R1: With prescale limit P, the prescale count steps through 0..P and the timer count rises by one on each wrap, that is once every P+1 clocks. If software writes control = run while the block is clear, then after n further clock edges (n >= 1) the timer count reads floor((n-1)/(P+1)) and the prescale count reads (n-1) mod (P+1).
- R2: While control bit 1 (clear) is set, both counters read zero. Counting resumes from zero once the bit is cleared with bit 0 (run) set.
- R3: While the pause input is high, neither counter changes. Counting resumes at the first edge after pause falls.
- R4: A match occurs when a tick carries the count to a channel's match value. Match configuration bits [4c+1:4c] set channel c's action: 0 = none, 1 = restart, 2 = halt. On a halt match the count stays at the match value and control bit 0 reads 0.
- R5: On a restart match the count keeps the match value until the next tick, which loads 0. With limit 0 and match value M, the count after j ticks is j mod (M+1).
- R6: Match configuration bits [4c+3:4c+2] set pin c's behaviour on a match: 0 = unchanged, 1 = drive low, 2 = drive high, 3 = invert. Between matches the pin holds its level. Pin levels also read at address 16, bit c.
- R7: Capture configuration bit 2c enables rising-edge capture on channel c and bit 2c+1 enables falling-edge capture. After an enabled edge on input c, the capture register holds the count present after the second clock edge following the change, and flag bit 4+c is set.
- R8: An edge of a kind that is not enabled changes neither the capture register nor the flags.
- R9: Flag bits [3:0] (match) and [7:4] (capture) stay set until software writes a 1 to them. irq is the OR of the flags whose enable bit at address 2 is set.
- R10: After reset every readable register, every match pin and irq are zero, and the block is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pause_in | input | 1 | Freeze both counters while high |
| cap_in | input | N_CAP | Capture inputs, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data (combinational) |
| mat_out | output | N_MATCH | Match pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps prescale limits 0 to 3 against a range of elapsed cycle counts, so an off-by-one in the prescale wrap or a late start would shift every expected count. It runs each match channel through restart with inverting pins, so a design that restarted on the same tick as the match would skip the match value and toggle at the wrong period. It then runs each channel through halt with each fixed pin level, so a design that let one extra tick pass before halting would read match value + 1. For capture, the bench checks the exact sampled value after the synchroniser, so one missing or extra stage shows up as a wrong count. It also applies edges of the disabled kind, which would set a flag or overwrite the captured value in a design that ignored the edge enables.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_PAUSE = 2'd2,
        ST_COUNT = 2'd3
    } tmr_state_e;

    // match actions
    localparam logic [1:0] ACT_NONE    = 2'd0;
    localparam logic [1:0] ACT_RESTART = 2'd1;
    localparam logic [1:0] ACT_HALT    = 2'd2;

    // pin behaviour on a match
    localparam logic [1:0] PIN_KEEP   = 2'd0;
    localparam logic [1:0] PIN_LOW    = 2'd1;
    localparam logic [1:0] PIN_HIGH   = 2'd2;
    localparam logic [1:0] PIN_INVERT = 2'd3;

    // register word addresses
    localparam int unsigned RA_CTRL  = 0;
    localparam int unsigned RA_FLAGS = 1;
    localparam int unsigned RA_IEN   = 2;
    localparam int unsigned RA_COUNT = 3;
    localparam int unsigned RA_PLIM  = 4;
    localparam int unsigned RA_PCNT  = 5;
    localparam int unsigned RA_MCFG  = 6;
    localparam int unsigned RA_CCFG  = 7;
    localparam int unsigned RA_MVAL  = 8;

endpackage

// File: rtl/tmr_prescale_sm.sv
module tmr_prescale_sm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             pause,
    input  logic [CNT_W-1:0] lim,
    output logic             tick,
    output logic             clear_now,
    output logic [CNT_W-1:0] pre_cnt,
    output tmr_state_e       st
);

    tmr_state_e st_nx;
    logic       advance;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (clr)                st_nx = ST_CLEAR;
                else if (run && pause)  st_nx = ST_PAUSE;
                else if (run)           st_nx = ST_COUNT;
            end
            ST_CLEAR: begin
                if (!clr) begin
                    if (!run)           st_nx = ST_IDLE;
                    else if (pause)     st_nx = ST_PAUSE;
                    else                st_nx = ST_COUNT;
                end
            end
            ST_PAUSE: begin
                if (clr)                st_nx = ST_CLEAR;
                else if (!run)          st_nx = ST_IDLE;
                else if (!pause)        st_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (clr)                st_nx = ST_CLEAR;
                else if (!run)          st_nx = ST_IDLE;
                else if (pause)         st_nx = ST_PAUSE;
            end
            default:                    st_nx = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        clear_now = (st == ST_CLEAR);
        advance   = run && !clr && !pause &&
                    ((st == ST_COUNT) || (st == ST_PAUSE));
        tick      = advance && (pre_cnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pre_cnt <= '0;
        else if (clear_now)  pre_cnt <= '0;
        else if (tick)       pre_cnt <= '0;
        else if (advance)    pre_cnt <= pre_cnt + CNT_W'(1);
    end

endmodule

// File: rtl/tmr_match_ch.sv
module tmr_match_ch
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] nxt_val,
    input  logic [CNT_W-1:0] mval,
    input  logic [1:0]       pin_mode,
    output logic             hit,
    output logic             pin
);

    assign hit = tick && (nxt_val == mval);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (hit) begin
            unique case (pin_mode)
                PIN_KEEP:   pin <= pin;
                PIN_LOW:    pin <= 1'b0;
                PIN_HIGH:   pin <= 1'b1;
                PIN_INVERT: pin <= ~pin;
                default:    pin <= pin;
            endcase
        end
    end

endmodule

// File: rtl/tmr_capture_ch.sv
module tmr_capture_ch #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic [CNT_W-1:0] count,
    output logic             ev,
    output logic [CNT_W-1:0] cap_val
);

    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= cap_pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign ev = (rise_en && s2 && !s3) || (fall_en && !s2 && s3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cap_val <= '0;
        else if (ev) cap_val <= count;
    end

endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 4,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pause_in,
    input  logic [N_CAP-1:0]  cap_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [N_MATCH-1:0] mat_out,
    output logic              irq
);

    localparam int NF       = N_MATCH + N_CAP;
    localparam int MW       = 4 * N_MATCH;
    localparam int CW       = 2 * N_CAP;
    localparam int CAP_BASE = RA_MVAL + N_MATCH;
    localparam int PIN_ADDR = CAP_BASE + N_CAP;

    logic             run_q, clr_q;
    logic [NF-1:0]    flags_q, ien_q, flags_clr;
    logic [CNT_W-1:0] lim_q, tc_q, nxt_val, pre_cnt;
    logic [MW-1:0]    mcfg_q;
    logic [CW-1:0]    ccfg_q;
    logic [CNT_W-1:0] mval_q  [N_MATCH];
    logic [CNT_W-1:0] cap_val [N_CAP];
    logic [N_MATCH-1:0] hit, halt_mask, restart_mask;
    logic [N_CAP-1:0]   cap_ev;
    logic             tick, clear_now, restart_pend;
    logic             halt_any, restart_any;
    tmr_state_e       st;

    function automatic logic wr_at(input int unsigned a);
        return reg_we && (reg_addr == ADDR_W'(a));
    endfunction

    tmr_prescale_sm #(.CNT_W(CNT_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .clr       (clr_q),
        .pause     (pause_in),
        .lim       (lim_q),
        .tick      (tick),
        .clear_now (clear_now),
        .pre_cnt   (pre_cnt),
        .st        (st)
    );

    assign nxt_val = restart_pend ? '0 : tc_q + CNT_W'(1);

    for (genvar i = 0; i < N_MATCH; i++) begin : g_match
        tmr_match_ch #(.CNT_W(CNT_W)) u_m (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .nxt_val  (nxt_val),
            .mval     (mval_q[i]),
            .pin_mode (mcfg_q[4*i+3 -: 2]),
            .hit      (hit[i]),
            .pin      (mat_out[i])
        );
        assign halt_mask[i]    = (mcfg_q[4*i+1 -: 2] == ACT_HALT);
        assign restart_mask[i] = (mcfg_q[4*i+1 -: 2] == ACT_RESTART);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  mval_q[i] <= '0;
            else if (wr_at(RA_MVAL + i)) mval_q[i] <= reg_wdata;
        end
    end

    for (genvar k = 0; k < N_CAP; k++) begin : g_cap
        tmr_capture_ch #(.CNT_W(CNT_W)) u_c (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_pin (cap_in[k]),
            .rise_en (ccfg_q[2*k]),
            .fall_en (ccfg_q[2*k+1]),
            .count   (tc_q),
            .ev      (cap_ev[k]),
            .cap_val (cap_val[k])
        );
    end

    assign halt_any    = |(hit & halt_mask);
    assign restart_any = |(hit & restart_mask);
    assign flags_clr   = wr_at(RA_FLAGS) ? reg_wdata[NF-1:0] : '0;

    // control and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            clr_q  <= 1'b0;
            ien_q  <= '0;
            lim_q  <= '0;
            mcfg_q <= '0;
            ccfg_q <= '0;
        end else begin
            if (wr_at(RA_CTRL)) begin
                run_q <= reg_wdata[0];
                clr_q <= reg_wdata[1];
            end
            if (halt_any)       run_q  <= 1'b0;
            if (wr_at(RA_IEN))  ien_q  <= reg_wdata[NF-1:0];
            if (wr_at(RA_PLIM)) lim_q  <= reg_wdata;
            if (wr_at(RA_MCFG)) mcfg_q <= reg_wdata[MW-1:0];
            if (wr_at(RA_CCFG)) ccfg_q <= reg_wdata[CW-1:0];
        end
    end

    // timer count and restart bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q         <= '0;
            restart_pend <= 1'b0;
        end else if (clear_now) begin
            tc_q         <= '0;
            restart_pend <= 1'b0;
        end else if (tick) begin
            tc_q         <= nxt_val;
            restart_pend <= restart_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flags_clr) | {cap_ev, hit};
    end

    assign irq = |(flags_q & ien_q);

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(RA_CTRL):  reg_rdata = CNT_W'({clr_q, run_q});
            ADDR_W'(RA_FLAGS): reg_rdata = CNT_W'(flags_q);
            ADDR_W'(RA_IEN):   reg_rdata = CNT_W'(ien_q);
            ADDR_W'(RA_COUNT): reg_rdata = tc_q;
            ADDR_W'(RA_PLIM):  reg_rdata = lim_q;
            ADDR_W'(RA_PCNT):  reg_rdata = pre_cnt;
            ADDR_W'(RA_MCFG):  reg_rdata = CNT_W'(mcfg_q);
            ADDR_W'(RA_CCFG):  reg_rdata = CNT_W'(ccfg_q);
            ADDR_W'(PIN_ADDR): reg_rdata = CNT_W'(mat_out);
            default: begin
                for (int i = 0; i < N_MATCH; i++)
                    if (reg_addr == ADDR_W'(RA_MVAL + i)) reg_rdata = mval_q[i];
                for (int k = 0; k < N_CAP; k++)
                    if (reg_addr == ADDR_W'(CAP_BASE + k)) reg_rdata = cap_val[k];
            end
        endcase
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 4,
    parameter int ADDR_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pause_in,
    input logic                     clear_now,
    input logic                     tick,
    input logic [CNT_W-1:0]         tc,
    input logic [N_MATCH+N_CAP-1:0] flags,
    input logic [N_MATCH+N_CAP-1:0] ien,
    input logic                     irq,
    input logic [N_MATCH-1:0]       hit,
    input logic [N_MATCH-1:0]       halt_mask,
    input logic                     run_q,
    input logic [N_MATCH-1:0]       mat_out,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr
);

    logic flag_wr;
    assign flag_wr = reg_we && (reg_addr == ADDR_W'(RA_FLAGS));

    assert_count_only_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear_now) |=> $stable(tc));

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> (tc == '0));

    assert_pause_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_in && !clear_now) |=> $stable(tc));

    assert_halt_drops_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & halt_mask)) |=> !run_q);

    assert_pin_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> $stable(mat_out));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flags & $past(flags)) == $past(flags)));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

endmodule

bind tmr_match_capture tmr_checker #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause_in  (pause_in),
    .clear_now (clear_now),
    .tick      (tick),
    .tc        (tc_q),
    .flags     (flags_q),
    .ien       (ien_q),
    .irq       (irq),
    .hit       (hit),
    .halt_mask (halt_mask),
    .run_q     (run_q),
    .mat_out   (mat_out),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr)
);

// File: tb/tb_tmr_match_capture.sv
module tb_tmr_match_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause_in = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  mat_out;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tmr_match_capture dut (
        .clk(clk), .rst_n(rst_n), .pause_in(pause_in), .cap_in(cap_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mat_out(mat_out), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic start(input int p);
        wr(4, 32'(p));
        wr(0, 32'd2);
        wr(0, 32'd1);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, t0, c0;
        logic        p0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R10: reset state
        for (int a = 0; a <= 16; a++) begin
            rd(a, v);
            check("R10 reg", v, 0);
        end
        check("R10 pins", 32'(mat_out), 0);
        check("R10 irq", 32'(irq), 0);

        // R1: prescale sweep
        for (int p = 0; p < 4; p++) begin
            for (int n = 1; n <= 10; n++) begin
                start(p);
                wait_n(n);
                rd(3, v); check("R1 count", v, 32'((n - 1) / (p + 1)));
                rd(5, v); check("R1 prescale", v, 32'((n - 1) % (p + 1)));
            end
        end

        // R2: clear holds zero, then counting restarts
        start(0);
        wait_n(6);
        wr(0, 32'd3);
        wait_n(5);
        rd(3, v); check("R2 count held", v, 0);
        rd(5, v); check("R2 prescale held", v, 0);
        wr(0, 32'd1);
        wait_n(4);
        rd(3, v); check("R2 resume", v, 3);

        // R3: pause
        start(0);
        wait_n(5);
        rd(3, v); check("R3 before pause", v, 4);
        pause_in = 1'b1;
        wait_n(6);
        rd(3, v); check("R3 paused", v, 4);
        pause_in = 1'b0;
        wait_n(3);
        rd(3, v); check("R3 resumed", v, 7);

        // R5 and R6: restart action with inverting pin, match value 3
        for (int c = 0; c < 4; c++) begin
            wr(6, 32'(13) << (4 * c));
            wr(8 + c, 32'd3);
            for (int n = 1; n <= 12; n++) begin
                start(0);
                p0 = mat_out[c];
                wait_n(n);
                rd(3, v); check("R5 restart count", v, 32'((n - 1) % 4));
                check("R6 invert pin", 32'(mat_out[c]), 32'(p0 ^ ((n / 4) % 2 == 1)));
            end
        end

        // R4 and R6: halt action with high, keep, low pin modes
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 3; m++) begin
                int mode;
                int expect_pin;
                mode = (m == 0) ? 2 : (m == 1) ? 0 : 1;
                expect_pin = (m == 2) ? 0 : 1;
                wr(6, 32'(2 | (mode << 2)) << (4 * c));
                wr(8 + c, 32'd5);
                wr(1, 32'hFF);
                start(1);
                wait_n(30);
                rd(3, v); check("R4 halted count", v, 5);
                rd(0, v); check("R4 run cleared", v, 0);
                rd(1, v); check("R9 match flag", 32'(v[c]), 1);
                check("R6 fixed pin", 32'(mat_out[c]), 32'(expect_pin));
                rd(16, v); check("R6 pin readback", 32'(v[c]), 32'(expect_pin));
            end
            // R9: enable gating and write-one-to-clear
            check("R9 irq masked", 32'(irq), 0);
            wr(2, 32'd1 << c);
            check("R9 irq enabled", 32'(irq), 1);
            wr(1, 32'hFF);
            check("R9 irq after clear", 32'(irq), 0);
            rd(1, v); check("R9 flags cleared", v, 0);
            wr(2, 32'd0);
        end

        // R7 and R8: capture edges
        wr(6, 32'd0);
        for (int c = 0; c < 4; c++) begin
            wr(7, 32'd1 << (2 * c));
            wr(1, 32'hFF);
            start(0);
            wait_n(10);
            rd(3, t0);
            cap_in[c] = 1'b1;
            wait_n(3);
            rd(12 + c, c0); check("R7 rising capture", c0, t0 + 2);
            rd(1, v); check("R7 capture flag", 32'(v[4 + c]), 1);
            wr(1, 32'hFF);
            cap_in[c] = 1'b0;
            wait_n(6);
            rd(12 + c, v); check("R8 falling ignored", v, c0);
            rd(1, v); check("R8 no flag", 32'(v[4 + c]), 0);
            wr(7, 32'd2 << (2 * c));
            cap_in[c] = 1'b1;
            wait_n(6);
            rd(12 + c, v); check("R8 rising ignored", v, c0);
            rd(3, t0);
            cap_in[c] = 1'b0;
            wait_n(3);
            rd(12 + c, v); check("R7 falling capture", v, t0 + 2);
            rd(1, v); check("R7 falling flag", 32'(v[4 + c]), 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule